// File: doc/BRIEF.md
# Configuration-Space Bus Walker

This block discovers every function behind a host bridge by walking configuration space depth-first, starting at bus 0. On each bus it steps through device numbers 0 to 31 and, within a device, function numbers 0 to 7. For each slot it issues single-dword configuration reads through a request/acknowledge port: first the identification dword, then the dword holding the header type, and, for bridge headers, the dword holding the secondary bus number.

Every function that answers is handed out on a valid/ready report stream as (bus, device, function, raw header-type byte). When a bridge leads to a higher-numbered bus, the walker pushes its current position onto a small internal stack. It then scans the child bus and later resumes the parent at the next function. A software enumerator or a boot sequencer pulses `start`, drains the report stream and waits for `done`.

Top module: `pci_enum_walker`

## Requirements
- R1: After reset the walker is idle: `cfg_req`, `rep_valid`, `busy`, `done` and `overflow` are all 0.
- R2: Configuration reads use only dword index 0 (identification, vendor ID in bits 15:0), 3 (header type in bits 23:16, byte offset 0x0E) and 6 (secondary bus number in bits 15:8, byte offset 0x19). Slots are visited in ascending device order and, within a device, ascending function order.
- R3: A vendor ID of 0xFFFF marks an empty slot. At function 0 the rest of that device is skipped; at functions 1 to 7 the walk continues with the next function.
- R4: Bit 7 of the header byte read at function 0 selects multifunction scanning. If that bit is clear, functions 1 to 7 of that device are never read.
- R5: Each present function produces exactly one report carrying its bus, device, function and the unmodified header byte. The report is issued before the secondary bus number is read and before any descent.
- R6: The secondary bus number is read only when the header byte ANDed with 0x7F equals 1 (PCI-to-PCI bridge) or 2 (CardBus bridge).
- R7: A descent into the secondary bus happens only when that number is strictly greater than the current bus. After the child bus is finished, the parent walk resumes at its next function.
- R8: At most STACK_DEPTH (default 4) descents can be nested. A descent attempted with a full stack is dropped, and the `overflow` flag is set. That flag stays set until the next accepted `start`, which clears it.
- R9: `done` rises once device 31 of bus 0 has been finished with the stack empty. It stays high, with no further reads or reports, until the next `start`.
- R10: A pending configuration request keeps its address stable until `cfg_ack`. A pending report keeps its fields stable until `rep_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; accepted only while idle or done |
| cfg_req | output | 1 | Configuration read request |
| cfg_bus | output | 8 | Bus number of the read |
| cfg_dev | output | 5 | Device number of the read |
| cfg_fn | output | 3 | Function number of the read |
| cfg_dword | output | 6 | Dword index within the 256-byte header |
| cfg_ack | input | 1 | Read completes this cycle, `cfg_rdata` valid |
| cfg_rdata | input | 32 | Read data |
| rep_valid | output | 1 | Report available |
| rep_ready | input | 1 | Consumer accepts the report |
| rep_bus | output | 8 | Bus of the reported function |
| rep_dev | output | 5 | Device of the reported function |
| rep_fn | output | 3 | Function number of the reported function |
| rep_hdr | output | 8 | Raw header-type byte |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished |
| overflow | output | 1 | Sticky: a descent was dropped for lack of stack |

## Verification
The first topology is flat: one bus holding a single-function device, a multifunction device with holes, a device absent at function 0 but populated higher up, and a single-function device whose higher functions would answer. This topology separates the empty-slot rule from the multifunction rule through the exact report list and the number of identification reads. The second topology mixes PCI and CardBus bridges, a multifunction bridge, a bridge pointing back to a lower bus, one pointing to its own bus, and a non-bridge header that carries a secondary number. All of this runs under a throttled report consumer, so the test distinguishes nesting order, resume position and descent filtering. A chain of bridges deeper than the stack shows the dropped descent and the sticky flag. A restart then shows the flag being cleared.

// File: rtl/pci_enum_walker.sv
module pci_enum_walker #(
  parameter int STACK_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       cfg_req,
  output logic [7:0] cfg_bus,
  output logic [4:0] cfg_dev,
  output logic [2:0] cfg_fn,
  output logic [5:0] cfg_dword,
  input  logic       cfg_ack,
  input  logic [31:0] cfg_rdata,
  output logic       rep_valid,
  input  logic       rep_ready,
  output logic [7:0] rep_bus,
  output logic [4:0] rep_dev,
  output logic [2:0] rep_fn,
  output logic [7:0] rep_hdr,
  output logic       busy,
  output logic       done,
  output logic       overflow
);
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int ENT_W = 8 + 5 + 3 + 1;
  localparam int SLOTS = 1 << IDX_W;
  localparam logic [5:0] DW_ID  = 6'd0;
  localparam logic [5:0] DW_HDR = 6'd3;
  localparam logic [5:0] DW_SEC = 6'd6;

  typedef enum logic [2:0] {S_IDLE, S_VID, S_HDR, S_REP, S_SEC, S_ADV, S_DONE} st_t;

  st_t              state;
  logic [7:0]       bus;
  logic [4:0]       dev;
  logic [2:0]       fn;
  logic             multi;
  logic [7:0]       hdr;
  logic [SP_W-1:0]  sp;
  logic             ovf;
  logic [ENT_W-1:0] stk [SLOTS];

  wire [15:0]      vid     = cfg_rdata[15:0];
  wire [7:0]       hdr_in  = cfg_rdata[23:16];
  wire [7:0]       sec_in  = cfg_rdata[15:8];
  wire             sp_full = (sp == SP_W'(STACK_DEPTH));
  wire [SP_W-1:0]  sp_m1   = sp - 1'b1;
  wire [6:0]       layout  = hdr[6:0];
  wire             bridge  = (layout == 7'd1) || (layout == 7'd2);
  wire             push    = (state == S_SEC) && cfg_ack && (sec_in > bus) && !sp_full;
  logic            unused_bits;
  assign unused_bits = ^{cfg_rdata[31:24], cfg_rdata[7:0]};

  always_ff @(posedge clk) begin
    if (push) stk[sp[IDX_W-1:0]] <= {bus, dev, fn, multi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bus   <= '0;
      dev   <= '0;
      fn    <= '0;
      multi <= 1'b0;
      hdr   <= '0;
      sp    <= '0;
      ovf   <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          bus   <= '0;
          dev   <= '0;
          fn    <= '0;
          multi <= 1'b0;
          sp    <= '0;
          ovf   <= 1'b0;
          state <= S_VID;
        end
        S_VID: if (cfg_ack) begin
          if (vid == 16'hFFFF) begin
            if (fn == 3'd0) multi <= 1'b0;
            state <= S_ADV;
          end else begin
            state <= S_HDR;
          end
        end
        S_HDR: if (cfg_ack) begin
          hdr <= hdr_in;
          if (fn == 3'd0) multi <= hdr_in[7];
          state <= S_REP;
        end
        S_REP: if (rep_ready) state <= bridge ? S_SEC : S_ADV;
        S_SEC: if (cfg_ack) begin
          if (sec_in > bus) begin
            if (sp_full) begin
              ovf   <= 1'b1;
              state <= S_ADV;
            end else begin
              sp    <= sp + 1'b1;
              bus   <= sec_in;
              dev   <= '0;
              fn    <= '0;
              multi <= 1'b0;
              state <= S_VID;
            end
          end else begin
            state <= S_ADV;
          end
        end
        S_ADV: begin
          if (multi && fn != 3'd7) begin
            fn    <= fn + 1'b1;
            state <= S_VID;
          end else if (dev != 5'd31) begin
            dev   <= dev + 1'b1;
            fn    <= '0;
            multi <= 1'b0;
            state <= S_VID;
          end else if (sp == '0) begin
            state <= S_DONE;
          end else begin
            {bus, dev, fn, multi} <= stk[sp_m1[IDX_W-1:0]];
            sp <= sp_m1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cfg_req   = (state == S_VID) || (state == S_HDR) || (state == S_SEC);
  assign cfg_dword = (state == S_HDR) ? DW_HDR : (state == S_SEC) ? DW_SEC : DW_ID;
  assign cfg_bus   = bus;
  assign cfg_dev   = dev;
  assign cfg_fn    = fn;
  assign rep_valid = (state == S_REP);
  assign rep_bus   = bus;
  assign rep_dev   = dev;
  assign rep_fn    = fn;
  assign rep_hdr   = hdr;
  assign busy      = (state != S_IDLE) && (state != S_DONE);
  assign done      = (state == S_DONE);
  assign overflow  = ovf;
endmodule

module pci_enum_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cfg_req,
  input logic [7:0] cfg_bus,
  input logic [4:0] cfg_dev,
  input logic [2:0] cfg_fn,
  input logic [5:0] cfg_dword,
  input logic       cfg_ack,
  input logic       rep_valid,
  input logic       rep_ready,
  input logic [7:0] rep_bus,
  input logic [4:0] rep_dev,
  input logic [2:0] rep_fn,
  input logic [7:0] rep_hdr,
  input logic       busy,
  input logic       done,
  input logic       overflow
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable({cfg_bus, cfg_dev, cfg_fn, cfg_dword}));
  p_rep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable({rep_bus, rep_dev, rep_fn, rep_hdr}));
  p_dword_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_dword == 6'd0 || cfg_dword == 6'd3 || cfg_dword == 6'd6));
  p_report_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && rep_valid));
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cfg_req && !rep_valid && !busy);
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !start |=> overflow);
endmodule

bind pci_enum_walker pci_enum_walker_chk u_chk (.*);

// File: tb/test_pci_enum_walker.sv
module test_pci_enum_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cfg_ack, rep_ready;
  logic [31:0] cfg_rdata;
  logic cfg_req, rep_valid, busy, done, overflow;
  logic [7:0] cfg_bus, rep_bus, rep_hdr;
  logic [4:0] cfg_dev, rep_dev;
  logic [2:0] cfg_fn, rep_fn;
  logic [5:0] cfg_dword;

  always #10 clk = ~clk;

  pci_enum_walker i_pci_enum_walker (.*);

  logic       present [8][32][8];
  logic [7:0] hdr_m   [8][32][8];
  logic [7:0] sec_m   [8][32][8];
  logic [23:0] got_q[$];
  logic [23:0] exp_q[$];
  int checks = 0, fails = 0, cyc = 0;
  int vid_reads = 0, sec_reads = 0, bad_dw = 0;
  logic bp_mode = 1'b0;

  function automatic logic [31:0] model(input logic [7:0] b, input logic [4:0] d,
                                         input logic [2:0] f, input logic [5:0] dw);
    logic p;
    p = (b < 8'd8) && present[b[2:0]][d][f];
    if (!p) return (dw == 6'd0) ? 32'hFFFF_FFFF : 32'h0;
    case (dw)
      6'd0: return {16'hBEEF, 16'h1D0C};
      6'd3: return {8'h00, hdr_m[b[2:0]][d][f], 8'h00, 8'h10};
      6'd6: return {8'h40, 8'hFF, sec_m[b[2:0]][d][f], b};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [23:0] ent(input int b, input int d, input int f, input int h);
    return {b[7:0], d[4:0], f[2:0], h[7:0]};
  endfunction

  initial begin
    cfg_ack = 1'b0; cfg_rdata = '0; rep_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      cfg_ack   = cfg_req;
      cfg_rdata = cfg_req ? model(cfg_bus, cfg_dev, cfg_fn, cfg_dword) : 32'h0;
      if (cfg_req) begin
        if (cfg_dword == 6'd0) vid_reads++;
        else if (cfg_dword == 6'd6) sec_reads++;
        else if (cfg_dword != 6'd3) bad_dw++;
      end
      rep_ready = bp_mode ? cyc[1] : 1'b1;
      if (rep_valid && rep_ready) got_q.push_back({rep_bus, rep_dev, rep_fn, rep_hdr});
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int b = 0; b < 8; b++)
      for (int d = 0; d < 32; d++)
        for (int f = 0; f < 8; f++) begin
          present[b][d][f] = 1'b0; hdr_m[b][d][f] = 8'h00; sec_m[b][d][f] = 8'h00;
        end
    exp_q.delete();
  endtask

  task automatic put(input int b, input int d, input int f, input int h, input int s);
    present[b][d][f] = 1'b1; hdr_m[b][d][f] = h[7:0]; sec_m[b][d][f] = s[7:0];
  endtask

  task automatic run_scan(input string tag);
    int n;
    got_q.delete(); vid_reads = 0; sec_reads = 0; bad_dw = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R9 busy during walk"}, {31'b0, done}, 32'd0);
    n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    chk({tag, " R9 done reached"}, {31'b0, done}, 32'd1);
    chk({tag, " R5 report count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({tag, " R2 R5 report entry"}, {8'b0, got_q[i]}, {8'b0, exp_q[i]});
    chk({tag, " R2 dword legal"}, bad_dw, 0);
  endtask

  task automatic flat_model();
    clear_model();
    put(0, 0, 0, 8'h00, 0);
    put(0, 3, 0, 8'h80, 0); put(0, 3, 2, 8'h00, 0); put(0, 3, 7, 8'h00, 0);
    put(0, 5, 1, 8'h00, 0);
    put(0, 9, 0, 8'h00, 0); put(0, 9, 1, 8'h00, 0);
    put(0, 31, 0, 8'h00, 0);
    exp_q.push_back(ent(0, 0, 0, 8'h00)); exp_q.push_back(ent(0, 3, 0, 8'h80));
    exp_q.push_back(ent(0, 3, 2, 8'h00)); exp_q.push_back(ent(0, 3, 7, 8'h00));
    exp_q.push_back(ent(0, 9, 0, 8'h00)); exp_q.push_back(ent(0, 31, 0, 8'h00));
  endtask

  task automatic t_reset();
    chk("R1 cfg_req", {31'b0, cfg_req}, 0);
    chk("R1 rep_valid", {31'b0, rep_valid}, 0);
    chk("R1 busy/done/overflow", {29'b0, busy, done, overflow}, 0);
  endtask

  task automatic t_flat();
    flat_model();
    bp_mode = 1'b0;
    run_scan("flat R3 R4");
    chk("R3 R4 identification reads", vid_reads, 39);
    chk("R6 no secondary reads", sec_reads, 0);
    chk("R8 no overflow", {31'b0, overflow}, 0);
  endtask

  task automatic t_bridges();
    int n;
    clear_model();
    put(0, 2, 0, 8'h01, 1);
    put(1, 0, 0, 8'h00, 0);
    put(1, 4, 0, 8'h02, 2);
    put(2, 1, 0, 8'h00, 0);
    put(2, 3, 0, 8'h01, 2);
    put(0, 6, 0, 8'h81, 3); put(0, 6, 1, 8'h00, 0);
    put(3, 0, 0, 8'h00, 0);
    put(0, 7, 0, 8'h01, 0);
    put(0, 8, 0, 8'h05, 4);
    put(4, 0, 0, 8'h00, 0);
    exp_q.push_back(ent(0, 2, 0, 8'h01)); exp_q.push_back(ent(1, 0, 0, 8'h00));
    exp_q.push_back(ent(1, 4, 0, 8'h02)); exp_q.push_back(ent(2, 1, 0, 8'h00));
    exp_q.push_back(ent(2, 3, 0, 8'h01)); exp_q.push_back(ent(0, 6, 0, 8'h81));
    exp_q.push_back(ent(3, 0, 0, 8'h00)); exp_q.push_back(ent(0, 6, 1, 8'h00));
    exp_q.push_back(ent(0, 7, 0, 8'h01)); exp_q.push_back(ent(0, 8, 0, 8'h05));
    bp_mode = 1'b1;
    run_scan("bridges R6 R7");
    bp_mode = 1'b0;
    chk("R6 R7 secondary reads", sec_reads, 5);
    n = got_q.size();
    repeat (6) @(negedge clk);
    chk("R9 done holds", {31'b0, done}, 1);
    chk("R9 no reports after done", got_q.size(), n);
  endtask

  task automatic t_overflow();
    clear_model();
    for (int b = 0; b < 5; b++) put(b, 1, 0, 8'h01, b + 1);
    put(5, 0, 0, 8'h00, 0);
    put(4, 2, 0, 8'h00, 0);
    put(0, 3, 0, 8'h00, 0);
    for (int b = 0; b < 5; b++) exp_q.push_back(ent(b, 1, 0, 8'h01));
    exp_q.push_back(ent(4, 2, 0, 8'h00));
    exp_q.push_back(ent(0, 3, 0, 8'h00));
    run_scan("overflow R8");
    chk("R8 overflow set", {31'b0, overflow}, 1);
    chk("R8 secondary reads", sec_reads, 5);
  endtask

  task automatic t_restart();
    flat_model();
    run_scan("restart R8");
    chk("R8 overflow cleared by start", {31'b0, overflow}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_bridges();
    t_overflow();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule